// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Unit

This unit raises interrupts for a calendar counter core. It has two sources. The periodic source follows one of six rollover strobes from the core: hundredths, tenths, seconds, minutes, hours or days. The alarm source compares the live time fields against an alarm target held in eight registers. Both sources are evaluated on the clock edge where the core presents a strobe. The alarm is checked only on hundredths strobes, so one matching time value gives exactly one alarm event.

Each source sets a sticky bit in a status register. One read of the status register returns the bits and clears them in the same access. A control register selects the periodic rate and enables each source onto one active-low interrupt line.

The block shares the core's 8-bit register bus. The core's decoder drives a select line, and a local 4-bit address picks the register. While the power-fail input is high, the bus has no effect. Interrupt generation carries on as normal during that time.

Top module: `irq_unit`

## Requirements
- R1: After reset the status register, the control register and all alarm fields read 0, and irq_n is high.
- R2: The control field rate (bits 2:0 of address 8) selects the periodic strobe. The codes are 0 hundredths, 1 tenths, 2 seconds, 3 minutes, 4 hours and 5 days. A pulse on the selected tick bit (tick[code]) sets status bit 0 at that clock edge. Pulses on the other tick bits do not set it.
- R3: Rate codes 6 and 7 never set status bit 0.
- R4: Status bit 1 is set at an edge where tick[0] is high and all eight time inputs equal their alarm fields. A match without tick[0] does not set it, and a mismatch in any single field does not set it.
- R5: A read of address 9 returns the status bits in bits 1:0, with bits 7:2 reading 0, and clears the bits at that edge. A source event in the same cycle as the clearing read is kept.
- R6: irq_n is low exactly when (status bit 0 and control bit 3) or (status bit 1 and control bit 4). Status bits are set even when their enable bit is 0.
- R7: While pwr_fail is high, writes are ignored, reads return 0, status is not cleared, and both sources still set status and drive irq_n.
- R8: The alarm fields are at addresses 0 to 7, in the order hundredths, seconds, minutes, hours, date, month, year and weekday. Each field keeps only its low bits, and the unused upper bits read 0. The control register is at address 8 and holds all 8 bits. Addresses 10 to 15 read 0. With bus_sel low, the bus has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Block select from the shared decoder |
| bus_addr | input | 4 | Local register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not reading) |
| pwr_fail | input | 1 | Power-fail: blocks the bus |
| tick | input | 6 | Rollover strobes: hundredths, tenths, sec, min, hour, day |
| now_hund | input | 7 | Live hundredths |
| now_sec | input | 6 | Live seconds |
| now_min | input | 6 | Live minutes |
| now_hour | input | 6 | Live hours |
| now_date | input | 5 | Live date |
| now_month | input | 4 | Live month |
| now_year | input | 7 | Live year |
| now_dow | input | 3 | Live weekday |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A tick pulse held for one cycle lands in the status register at the next clock edge. irq_n follows that register without delay, so the bench checks irq_n one time step after that edge. Read data is combinational, so the monitor samples bus_rdata at the falling edge inside the read cycle. The clear takes effect at the edge that ends the read, which is why every follow-up status read is a separate access. The same-cycle set-and-clear case drives the read and the tick in one cycle. It expects the old value from that read and the new bit from the next read.

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int N_RATES = 6,
  parameter int HUND_W  = 7,
  parameter int SEC_W   = 6,
  parameter int MIN_W   = 6,
  parameter int HOUR_W  = 6,
  parameter int DATE_W  = 5,
  parameter int MON_W   = 4,
  parameter int YEAR_W  = 7,
  parameter int DOW_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               pwr_fail,
  input  logic [N_RATES-1:0] tick,
  input  logic [HUND_W-1:0]  now_hund,
  input  logic [SEC_W-1:0]   now_sec,
  input  logic [MIN_W-1:0]   now_min,
  input  logic [HOUR_W-1:0]  now_hour,
  input  logic [DATE_W-1:0]  now_date,
  input  logic [MON_W-1:0]   now_month,
  input  logic [YEAR_W-1:0]  now_year,
  input  logic [DOW_W-1:0]   now_dow,
  output logic               irq_n
);
  localparam logic [ADDR_W-1:0] A_HUND  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_DOW   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(9);
  localparam int RATE_W = 3;

  logic [HUND_W-1:0]  al_hund;
  logic [SEC_W-1:0]   al_sec;
  logic [MIN_W-1:0]   al_min;
  logic [HOUR_W-1:0]  al_hour;
  logic [DATE_W-1:0]  al_date;
  logic [MON_W-1:0]   al_month;
  logic [YEAR_W-1:0]  al_year;
  logic [DOW_W-1:0]   al_dow;
  logic [DATA_W-1:0]  ctrl_q;
  logic [1:0]         status_q;

  logic bus_ok, wr_en, rd_en, stat_clr;
  logic per_hit, alarm_eq, alarm_hit;
  logic [RATE_W-1:0] rate;
  logic [1:0] src_en;

  assign bus_ok   = bus_sel & ~pwr_fail;
  assign wr_en    = bus_ok & bus_wr;
  assign rd_en    = bus_ok & bus_rd;
  assign stat_clr = rd_en & (bus_addr == A_STAT);
  assign rate     = ctrl_q[RATE_W-1:0];
  assign src_en   = {ctrl_q[4], ctrl_q[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_hund  <= '0;
      al_sec   <= '0;
      al_min   <= '0;
      al_hour  <= '0;
      al_date  <= '0;
      al_month <= '0;
      al_year  <= '0;
      al_dow   <= '0;
      ctrl_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_HUND:  al_hund  <= bus_wdata[HUND_W-1:0];
        A_SEC:   al_sec   <= bus_wdata[SEC_W-1:0];
        A_MIN:   al_min   <= bus_wdata[MIN_W-1:0];
        A_HOUR:  al_hour  <= bus_wdata[HOUR_W-1:0];
        A_DATE:  al_date  <= bus_wdata[DATE_W-1:0];
        A_MONTH: al_month <= bus_wdata[MON_W-1:0];
        A_YEAR:  al_year  <= bus_wdata[YEAR_W-1:0];
        A_DOW:   al_dow   <= bus_wdata[DOW_W-1:0];
        A_CTRL:  ctrl_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    per_hit = 1'b0;
    for (int i = 0; i < N_RATES; i++)
      if (rate == RATE_W'(i)) per_hit = tick[i];
  end

  assign alarm_eq = (now_hund == al_hund) && (now_sec == al_sec) &&
                    (now_min == al_min) && (now_hour == al_hour) &&
                    (now_date == al_date) && (now_month == al_month) &&
                    (now_year == al_year) && (now_dow == al_dow);
  assign alarm_hit = tick[0] & alarm_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~{2{stat_clr}}) | {alarm_hit, per_hit};
  end

  assign irq_n = ~|(status_q & src_en);

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (bus_addr)
        A_HUND:  bus_rdata = DATA_W'(al_hund);
        A_SEC:   bus_rdata = DATA_W'(al_sec);
        A_MIN:   bus_rdata = DATA_W'(al_min);
        A_HOUR:  bus_rdata = DATA_W'(al_hour);
        A_DATE:  bus_rdata = DATA_W'(al_date);
        A_MONTH: bus_rdata = DATA_W'(al_month);
        A_YEAR:  bus_rdata = DATA_W'(al_year);
        A_DOW:   bus_rdata = DATA_W'(al_dow);
        A_CTRL:  bus_rdata = ctrl_q;
        A_STAT:  bus_rdata = DATA_W'(status_q);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int N_RATES = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic               pwr_fail,
  input logic [N_RATES-1:0] tick,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_n,
  input logic [1:0]         status_q,
  input logic [DATA_W-1:0]  ctrl_q
);
  logic clr_req;
  assign clr_req = bus_sel && bus_rd && !pwr_fail && (bus_addr == ADDR_W'(9));

  assert_periodic_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[0]) |-> $past(|tick));

  assert_no_periodic_bad_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2:0] >= 3'(N_RATES) && !clr_req) |=> $stable(status_q[0]));

  assert_alarm_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick[0] && !clr_req) |=> $stable(status_q[1]));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && tick == '0) |=> (status_q == 2'b00));

  assert_irq_needs_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (status_q != 2'b00));

  assert_pwrfail_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (bus_rdata == '0));

  assert_pwrfail_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && bus_wr) |=> $stable(ctrl_q));
endmodule

bind irq_unit irq_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_RATES(N_RATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .pwr_fail(pwr_fail), .tick(tick),
  .bus_rdata(bus_rdata), .irq_n(irq_n), .status_q(status_q), .ctrl_q(ctrl_q)
);

// File: tb/test_irq_unit.sv
`timescale 1ns/1ps
module test_irq_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, pwr_fail = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] tick = '0;
  logic [6:0] now_hund = '0;
  logic [5:0] now_sec = '0, now_min = '0, now_hour = '0;
  logic [4:0] now_date = '0;
  logic [3:0] now_month = '0;
  logic [6:0] now_year = '0;
  logic [2:0] now_dow = '0;
  logic       irq_n;

  irq_unit i_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_fail(pwr_fail), .tick(tick), .now_hund(now_hund), .now_sec(now_sec),
    .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .now_month(now_month), .now_year(now_year), .now_dow(now_dow), .irq_n(irq_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) check("scoreboard underflow", bus_rdata, 8'hxx);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pulse(logic [5:0] m);
    @(posedge clk); #1; tick = m;
    @(posedge clk); #1; tick = '0;
  endtask

  task automatic chk_irq(logic exp, string tag);
    check(tag, {7'b0, irq_n}, {7'b0, exp});
  endtask

  task automatic match_time();
    now_hund = 7'h25; now_sec = 6'h17; now_min = 6'h2A; now_hour = 6'h13;
    now_date = 5'h0C; now_month = 4'h7; now_year = 7'h31; now_dow = 3'h4;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_irq(1'b1, "R1 irq_n after reset");
    bus_read(4'd9, 8'h00, "R1 status after reset");
    bus_read(4'd8, 8'h00, "R1 ctrl after reset");
    bus_read(4'd3, 8'h00, "R1 alarm hour after reset");

    bus_write(4'd0, 8'hA5); bus_write(4'd1, 8'h17); bus_write(4'd2, 8'h2A);
    bus_write(4'd3, 8'h13); bus_write(4'd4, 8'h0C); bus_write(4'd5, 8'h07);
    bus_write(4'd6, 8'h31); bus_write(4'd7, 8'h04);
    bus_read(4'd0, 8'h25, "R8 hund field truncated");
    bus_read(4'd6, 8'h31, "R8 year field");
    bus_read(4'd7, 8'h04, "R8 weekday field");

    bus_write(4'd8, 8'h0A);
    pulse(6'h01);
    bus_read(4'd9, 8'h00, "R2 unselected strobe ignored");
    pulse(6'h04);
    chk_irq(1'b0, "R6 irq on periodic");
    bus_read(4'd9, 8'h01, "R2 seconds rate sets status");
    bus_read(4'd9, 8'h00, "R5 status cleared by read");
    chk_irq(1'b1, "R6 irq released after clear");

    bus_write(4'd8, 8'h0D);
    pulse(6'h1F);
    bus_read(4'd9, 8'h00, "R2 day rate ignores lower strobes");
    pulse(6'h20);
    bus_read(4'd9, 8'h01, "R2 day rate sets status");

    bus_write(4'd8, 8'h0E);
    pulse(6'h3F);
    chk_irq(1'b1, "R3 rate 6 no irq");
    bus_read(4'd9, 8'h00, "R3 rate 6 no status");
    bus_write(4'd8, 8'h0F);
    pulse(6'h3F);
    bus_read(4'd9, 8'h00, "R3 rate 7 no status");

    match_time();
    bus_write(4'd8, 8'h16);
    repeat (3) @(posedge clk);
    bus_read(4'd9, 8'h00, "R4 match without tick ignored");
    pulse(6'h01);
    chk_irq(1'b0, "R6 irq on alarm");
    bus_read(4'd9, 8'h02, "R4 alarm sets status");
    chk_irq(1'b1, "R6 irq released");

    now_year = 7'h32;
    pulse(6'h01);
    bus_read(4'd9, 8'h00, "R4 year mismatch no alarm");
    now_year = 7'h31;

    bus_write(4'd8, 8'h06);
    pulse(6'h01);
    chk_irq(1'b1, "R6 disabled source no irq");
    bus_read(4'd9, 8'h02, "R6 status set while disabled");

    bus_write(4'd8, 8'h16);
    pwr_fail = 1'b1;
    bus_write(4'd8, 8'h00);
    pulse(6'h01);
    chk_irq(1'b0, "R7 irq during power fail");
    bus_read(4'd9, 8'h00, "R7 read returns zero");
    chk_irq(1'b0, "R7 status not cleared");
    pwr_fail = 1'b0;
    bus_read(4'd8, 8'h16, "R7 write ignored");
    bus_read(4'd9, 8'h02, "R7 status kept");

    @(posedge clk); #1;
    exp_q.push_back(8'h00); tag_q.push_back("R5 clearing read sees old value");
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 4'd9; tick = 6'h01;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_rd = 1'b0; tick = '0;
    bus_read(4'd9, 8'h02, "R5 set beats clear");

    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 8'hFF;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    bus_read(4'd8, 8'h16, "R8 unselected write ignored");
    bus_read(4'd12, 8'h00, "R8 unused address reads zero");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) check("scoreboard leftover", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    finish_run();
  end
endmodule